// File: doc/BRIEF.md
# Multiplexed Burst Pseudo-Static Memory Slave

This block is the slave-side front end of a 16-bit pseudo-static memory whose address and data share one bus. Every rising edge of `clk` it samples the control pins and decodes them into one of a handful of operations. The operations are asynchronous read and write, synchronous burst read and write, bus-configuration register read and write, standby, and idle. A small internal array, built from one RAM per byte lane, holds the data.

A 16-bit bus configuration register governs the block. Bit 15 selects asynchronous operation (1) or burst operation (0). Bit 10 sets the WAIT polarity: 1 means WAIT is high while data is not yet valid, and 0 inverts the pin.

In burst mode the block captures a start address and then waits a fixed latency. After that it transfers one word per clock from an internal address counter. The counter wraps within the array depth. The shared bus is modelled as a split input, output and output-enable, so that the inout can be built outside this block.

Top module: `psram_mux_slave`

## Requirements
- R1: With bus configuration bit 15 set (asynchronous mode), address capture never starts a burst and WAIT stays at its inactive level.
- R2: WAIT is at its active level only during burst latency. With bus configuration bit 10 set, the active level is 1. With bit 10 clear, the active level is 0 and WAIT idles at 1.
- R3: After reset the bus configuration register holds 0x8400 (bit 15 and bit 10 set), the bus is not driven and WAIT is 0.
- R4: An edge with ce_n=0, we_n=0, oe_n=1 and cre=1, while no burst is active, loads the bus configuration register from adq_in.
- R5: An edge with ce_n=0, oe_n=0, we_n=1 and cre=1, while no burst is active, drives the bus configuration register on adq_out (with adq_oe=1) for the following cycle.
- R6: In asynchronous mode, an edge with ce_n=0, adv_n=0 and cre=0 latches adq_in[AW-1:0] as the word address. An edge with adv_n=1, cre=0 and we_n=0 writes adq_in there. An edge with adv_n=1, cre=0, we_n=1 and oe_n=0 drives the stored word in the next cycle.
- R7: During array writes, lb_n=0 enables bits 7..0 and ub_n=0 enables bits 15..8. A disabled byte keeps its old value.
- R8: In burst mode, an edge with ce_n=0, adv_n=0 and cre=0 captures the start address and the direction (we_n=0 means write). While adv_n=1, adq_in is never taken as an address.
- R9: The first burst beat happens on the third edge after the capture edge. WAIT is active from the capture edge until that beat, and read data for the start address appears in the cycle after that beat.
- R10: Each later edge with ce_n=0 moves the burst to the next word address, modulo the array depth.
- R11: An edge with ce_n=1 ends any burst and releases the bus. Later edges with ce_n=0 and adv_n=1 transfer nothing until a new capture.
- R12: A burst read beat drives the bus only if oe_n=0 on that edge. The address still advances when oe_n=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address valid, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| cre | input | 1 | Steers the access to the configuration register when high |
| ub_n | input | 1 | Upper byte enable, active low |
| lb_n | input | 1 | Lower byte enable, active low |
| adq_in | input | 16 | Input side of the shared address/data bus |
| adq_out | output | 16 | Output side of the shared bus (0 when not driven) |
| adq_oe | output | 1 | High when the block drives the bus |
| wait_o | output | 1 | Burst WAIT flag with selectable polarity |

## Verification
The hardest state to reach is a burst that crosses the top of the array, because it must start near the end and run several beats. The stimulus captures a start address two words below the top and keeps reading until the counter has wrapped to address 1. Before that, every word is filled through asynchronous writes, so each word read back after the wrap is known. The write-then-read-back path for burst writes, and the effect of oe_n held high in the middle of a read burst, are covered the same way. A behavioural reference model compares the bus and WAIT on every cycle.

// File: rtl/psram_pkg.sv
package psram_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LAT, ST_DATA} bst_t;
  localparam int MODE_BIT = 15;
  localparam int WPOL_BIT = 10;
  localparam logic [15:0] CFG_RST = 16'h8400;
endpackage

// File: rtl/psram_lane_ram.sv
module psram_lane_ram #(
  parameter int AW = 4,
  parameter int W  = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/psram_cfg_reg.sv
module psram_cfg_reg import psram_pkg::*; (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  logic [15:0] wdata,
  output logic [15:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= CFG_RST;
    else if (wr) q <= wdata;
  end

  assert_cfg_reset_R3: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> q == CFG_RST);
endmodule

// File: rtl/psram_burst_ctrl.sv
module psram_burst_ctrl import psram_pkg::*; #(
  parameter int AW  = 4,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          burst_mode,
  input  logic          ce_n,
  input  logic          adv_n,
  input  logic          cre,
  input  logic          we_n,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] ptr,
  output logic          beat,
  output logic          beat_wr,
  output logic          in_lat,
  output logic          busy
);
  localparam int CW = $clog2(LAT + 1);

  bst_t          st;
  logic [CW-1:0] cnt;
  logic          dir_wr;
  logic          cap;

  assign cap     = !ce_n && !adv_n && !cre;
  assign beat    = !ce_n && !cap &&
                   ((st == ST_DATA) || (st == ST_LAT && cnt == CW'(LAT - 1)));
  assign beat_wr = beat && dir_wr;
  assign in_lat  = (st == ST_LAT);
  assign busy    = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      ptr    <= '0;
      dir_wr <= 1'b0;
    end else if (ce_n) begin
      st <= ST_IDLE;
    end else if (cap) begin
      ptr <= addr_in;
      if (burst_mode) begin
        st     <= ST_LAT;
        cnt    <= '0;
        dir_wr <= !we_n;
      end
    end else if (beat) begin
      st  <= ST_DATA;
      ptr <= ptr + 1'b1;
    end else if (st == ST_LAT) begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_ptr_step_R10: assert property (@(posedge clk) disable iff (rst)
    beat |=> ptr == AW'($past(ptr) + 1'b1));
  assert_lat_bound_R9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LAT) |-> cnt < CW'(LAT));
  assert_ce_end_R11: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> st == ST_IDLE);
endmodule

// File: rtl/psram_mux_slave.sv
module psram_mux_slave import psram_pkg::*; #(
  parameter int AW  = 4,
  parameter int LAT = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ce_n,
  input  logic        adv_n,
  input  logic        oe_n,
  input  logic        we_n,
  input  logic        cre,
  input  logic        ub_n,
  input  logic        lb_n,
  input  logic [15:0] adq_in,
  output logic [15:0] adq_out,
  output logic        adq_oe,
  output logic        wait_o
);
  localparam int NLANE = 2;

  logic [15:0]    cfg_q;
  logic [15:0]    mem_q;
  logic [AW-1:0]  ptr;
  logic           beat, beat_wr, in_lat, busy;
  logic           async_mode;
  logic           cfg_wr, cfg_rd, async_wr, async_rd;
  logic           oe_q, sel_cfg_q;
  logic [NLANE-1:0] be_n;

  assign async_mode = cfg_q[MODE_BIT];
  assign be_n       = {ub_n, lb_n};

  assign cfg_wr   = !ce_n && cre && !we_n && oe_n && !busy;
  assign cfg_rd   = !ce_n && cre && !oe_n && we_n && !busy;
  assign async_wr = async_mode && !ce_n && !cre && adv_n && !we_n;
  assign async_rd = async_mode && !ce_n && !cre && adv_n && we_n && !oe_n;

  psram_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .wr(cfg_wr), .wdata(adq_in), .q(cfg_q)
  );

  psram_burst_ctrl #(.AW(AW), .LAT(LAT)) u_ctrl (
    .clk(clk), .rst(rst), .burst_mode(!async_mode), .ce_n(ce_n),
    .adv_n(adv_n), .cre(cre), .we_n(we_n), .addr_in(adq_in[AW-1:0]),
    .ptr(ptr), .beat(beat), .beat_wr(beat_wr), .in_lat(in_lat), .busy(busy)
  );

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    psram_lane_ram #(.AW(AW), .W(8)) u_ram (
      .clk(clk),
      .we((async_wr || beat_wr) && !be_n[g]),
      .addr(ptr),
      .wdata(adq_in[8*g +: 8]),
      .rdata(mem_q[8*g +: 8])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q      <= 1'b0;
      sel_cfg_q <= 1'b0;
    end else begin
      oe_q      <= async_rd || cfg_rd || (beat && !beat_wr && !oe_n);
      sel_cfg_q <= cfg_rd;
    end
  end

  assign adq_oe  = oe_q;
  assign adq_out = oe_q ? (sel_cfg_q ? cfg_q : mem_q) : 16'h0000;
  assign wait_o  = cfg_q[WPOL_BIT] ? in_lat : !in_lat;

  assert_async_nowait_R1: assert property (@(posedge clk) disable iff (rst)
    async_mode |-> !busy);
  assert_standby_R11: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> !adq_oe);
  assert_decode_excl_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cfg_wr, cfg_rd, async_wr, async_rd, beat}));
  assert_wr_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (beat_wr || async_wr) |=> !adq_oe);
endmodule

// File: tb/psram_mux_slave_tb.sv
`timescale 1ns/1ps
module psram_mux_slave_tb;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic ce_n = 1, adv_n = 1, oe_n = 1, we_n = 1, cre = 0, ub_n = 0, lb_n = 0;
  logic [15:0] adq_in = 16'h0;
  logic [15:0] adq_out;
  logic adq_oe, wait_o;

  always #2.5 clk = ~clk;

  psram_mux_slave u_dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .adv_n(adv_n), .oe_n(oe_n),
    .we_n(we_n), .cre(cre), .ub_n(ub_n), .lb_n(lb_n), .adq_in(adq_in),
    .adq_out(adq_out), .adq_oe(adq_oe), .wait_o(wait_o)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R3";

  // behavioural reference model
  logic [15:0] m_mem [DEPTH];
  logic [15:0] m_cfg = 16'h8400, m_out = 0;
  int  m_st = 0, m_cnt = 0, m_ptr = 0;
  bit  m_dir = 0, m_oe = 0, m_wait = 0, m_on = 0;

  function automatic logic [15:0] merge(logic [15:0] old, logic [15:0] d);
    merge = old;
    if (!lb_n) merge[7:0]  = d[7:0];
    if (!ub_n) merge[15:8] = d[15:8];
  endfunction

  task automatic m_beat();
    if (m_dir) m_mem[m_ptr] = merge(m_mem[m_ptr], adq_in);
    else begin m_out = m_mem[m_ptr]; m_oe = !oe_n; end
    m_ptr = (m_ptr + 1) % DEPTH;
  endtask

  always @(posedge clk) begin
    m_oe = 0;
    if (rst) begin
      m_cfg = 16'h8400; m_st = 0; m_cnt = 0; m_ptr = 0; m_on = 1;
    end else if (ce_n) begin
      m_st = 0;
    end else if (!adv_n && !cre) begin
      m_ptr = adq_in % DEPTH;
      if (!m_cfg[15]) begin m_st = 1; m_cnt = 0; m_dir = !we_n; end
    end else if (m_st == 1) begin
      if (m_cnt == 2) begin m_beat(); m_st = 2; end
      else m_cnt++;
    end else if (m_st == 2) begin
      m_beat();
    end else if (cre) begin
      if (!we_n && oe_n) m_cfg = adq_in;
      else if (we_n && !oe_n) begin m_out = m_cfg; m_oe = 1; end
    end else if (m_cfg[15] && adv_n) begin
      if (!we_n) m_mem[m_ptr] = merge(m_mem[m_ptr], adq_in);
      else if (!oe_n) begin m_out = m_mem[m_ptr]; m_oe = 1; end
    end
    m_wait = (m_st == 1) ? m_cfg[10] : !m_cfg[10];
  end

  always @(negedge clk) begin
    if (m_on && !rst && !done) begin
      checks++;
      if (adq_oe !== m_oe || wait_o !== m_wait || (m_oe && adq_out !== m_out)) begin
        errors++;
        $display("FAIL %s cycle compare: oe=%b out=%h wait=%b expected oe=%b out=%h wait=%b",
                 tag, adq_oe, adq_out, wait_o, m_oe, m_out, m_wait);
      end
    end
  end

  task automatic chk(string rq, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic step(logic c, logic a, logic o, logic w, logic r,
                      logic ub, logic lb, logic [15:0] d);
    ce_n = c; adv_n = a; oe_n = o; we_n = w; cre = r; ub_n = ub; lb_n = lb; adq_in = d;
    @(negedge clk);
  endtask

  task automatic idle();              step(1,1,1,1,0,0,0,16'h0); endtask
  task automatic cfgw(logic [15:0] d); step(0,1,1,0,1,0,0,d); idle(); endtask
  task automatic cfgr();               step(0,1,0,1,1,0,0,16'h0); endtask
  task automatic aw(int a, logic [15:0] d, logic ub, logic lb);
    step(0,0,1,1,0,0,0,16'(a)); step(0,1,1,0,0,ub,lb,d); idle();
  endtask
  task automatic ar(int a);
    step(0,0,1,1,0,0,0,16'(a)); step(0,1,0,1,0,0,0,16'hDEAD);
  endtask

  function automatic logic [15:0] pat(int a);
    pat = 16'h5A00 + 16'(a) * 16'h0103;
  endfunction

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog during %s: actual hung expected finished", tag);
      report();
    end
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 0;
    idle();
    tag = "R3";
    chk("R3 bus idle after reset", {15'h0, adq_oe}, 16'h0);
    chk("R3 wait after reset", {15'h0, wait_o}, 16'h0);
    cfgr();
    tag = "R5";
    chk("R5/R3 config read", adq_out, 16'h8400);
    chk("R5 config read drives", {15'h0, adq_oe}, 16'h1);
    idle();

    tag = "R6";
    for (int a = 0; a < DEPTH; a++) aw(a, pat(a), 0, 0);
    ar(5);
    chk("R6 async read back", adq_out, pat(5));
    idle();

    tag = "R7";
    aw(6, 16'h1234, 1, 0);
    ar(6);
    chk("R7 lower byte only", adq_out, {pat(6)[15:8], 8'h34});
    idle();
    aw(7, 16'hABCD, 0, 1);
    ar(7);
    chk("R7 upper byte only", adq_out, {8'hAB, pat(7)[7:0]});
    idle();

    tag = "R2";
    cfgw(16'h8000);
    chk("R2 inverted idle wait", {15'h0, wait_o}, 16'h1);
    cfgw(16'h0000);
    step(0,0,1,1,0,0,0,16'h0);
    chk("R2 active-low wait in latency", {15'h0, wait_o}, 16'h0);
    step(0,1,0,1,0,0,0,16'h0); step(0,1,0,1,0,0,0,16'h0); step(0,1,0,1,0,0,0,16'h0);
    chk("R2 active-low wait released", {15'h0, wait_o}, 16'h1);
    idle();

    tag = "R4";
    cfgw(16'h0400);
    cfgr();
    chk("R4 config write taken", adq_out, 16'h0400);
    idle();

    tag = "R9";
    step(0,0,1,1,0,0,0,16'h0003);
    chk("R9 wait after capture", {15'h0, wait_o}, 16'h1);
    step(0,1,0,1,0,0,0,16'hFFFF);
    chk("R9 wait latency 1", {15'h0, wait_o}, 16'h1);
    step(0,1,0,1,0,0,0,16'h000B);
    chk("R8/R9 no data in latency", {15'h0, adq_oe}, 16'h0);
    step(0,1,0,1,0,0,0,16'h000C);
    chk("R9 wait released", {15'h0, wait_o}, 16'h0);
    chk("R9 first word", adq_out, pat(3));
    tag = "R10";
    step(0,1,0,1,0,0,0,16'h0000);
    chk("R10 second word", adq_out, pat(4));
    tag = "R12";
    step(0,1,1,1,0,0,0,16'h0000);
    chk("R12 oe high no drive", {15'h0, adq_oe}, 16'h0);
    step(0,1,0,1,0,0,0,16'h0000);
    chk("R12 address still advanced", adq_out, pat(6) & 16'hFF00 | 16'h0034);

    tag = "R11";
    idle();
    chk("R11 released on ce high", {15'h0, adq_oe}, 16'h0);
    step(0,1,0,1,0,0,0,16'h0001);
    step(0,1,0,1,0,0,0,16'h0001);
    chk("R11 no transfer without capture", {15'h0, adq_oe}, 16'h0);
    idle();

    tag = "R10";
    step(0,0,1,1,0,0,0,16'(DEPTH - 2));
    step(0,1,0,1,0,0,0,16'h0); step(0,1,0,1,0,0,0,16'h0); step(0,1,0,1,0,0,0,16'h0);
    chk("R10 word top-2", adq_out, pat(DEPTH - 2));
    step(0,1,0,1,0,0,0,16'h0);
    chk("R10 word top-1", adq_out, pat(DEPTH - 1));
    step(0,1,0,1,0,0,0,16'h0);
    chk("R10 wrap to 0", adq_out, pat(0));
    step(0,1,0,1,0,0,0,16'h0);
    chk("R10 wrap to 1", adq_out, pat(1));
    idle();

    tag = "R8";
    step(0,0,1,0,0,0,0,16'h0008);
    step(0,1,1,0,0,0,0,16'h1111); step(0,1,1,0,0,0,0,16'h2222);
    step(0,1,1,0,0,0,0,16'hC0DE); step(0,1,1,0,0,0,0,16'hC0DF); step(0,1,1,0,0,0,0,16'hC0E0);
    idle();
    step(0,0,1,1,0,0,0,16'h0008);
    step(0,1,0,1,0,0,0,16'h0); step(0,1,0,1,0,0,0,16'h0); step(0,1,0,1,0,0,0,16'h0);
    chk("R8 burst write word 0", adq_out, 16'hC0DE);
    step(0,1,0,1,0,0,0,16'h0);
    chk("R8 burst write word 1", adq_out, 16'hC0DF);
    step(0,1,0,1,0,0,0,16'h0);
    chk("R8 burst write word 2", adq_out, 16'hC0E0);
    idle();

    tag = "R1";
    cfgw(16'h8400);
    step(0,0,1,1,0,0,0,16'h0002);
    step(0,1,1,1,0,0,0,16'h0); step(0,1,1,1,0,0,0,16'h0);
    chk("R1 no latency in async mode", {15'h0, wait_o}, 16'h0);
    step(0,1,0,1,0,0,0,16'h0);
    chk("R1 async read after capture", adq_out, pat(2));
    idle(); idle();

    done = 1;
    report();
  end
endmodule